// File: doc/BRIEF.md
# Sampled Digital Input Noise Filter

This block cleans up one asynchronous external interrupt pin before an edge detector uses it. The pin is first brought into the system clock domain by a short synchroniser. A sample strobe then takes snapshots of it. The strobe comes from one tap of a free-running prescaler, or from an externally supplied slow subclock enable. The filtered level moves to a new value only when three successive samples all show that value. A narrow glitch therefore never reaches the interrupt logic.

Software sets the block up through one 8-bit control register. Bit 7 turns the digital filter on. When that bit is clear, the synchronised pin passes straight to the output. Bits 2:0 pick the sample source. A 2-bit edge-mode input decides which transitions of the filtered level raise a one-cycle edge pulse. Any write to the register reloads the sample history with the current synchronised pin level. This gives a defined starting point for the three-sample window that follows a change of source.

Top module: `pin_glitch_filter`

## Requirements
- R1: After reset the control register reads 0x00, the filtered level is 0 and no edge pulse is present.
- R2: The control register stores bit 7 (filter enable) and bits 2:0 (source select) exactly as written, including the prohibited codes. Bits 6:3 always read 0.
- R3: Select codes 0 to 4 take one sample every 2^(TAP_LO+code) system clocks from the prescaler. Code 5 takes one sample on each cycle in which `sub_tick` is high.
- R4: With select code 6 or 7 no samples are taken, so the filtered level holds whatever the pin does.
- R5: With the filter enabled, the filtered level changes only on a sample. After a pin change it takes the new value no earlier than 2P+3 and no later than 3P+2 clocks after the change, where P is the sample period.
- R6: A pin pulse lasting no more than one sample period never changes the filtered level.
- R7: A write to the control register reloads the sample history with the current synchronised pin level. One agreeing sample after the write is then enough to move the filtered level.
- R8: With bit 7 at 0, the filtered level equals the pin delayed by the two-flop synchroniser, which is two clocks.
- R9: With `div_stop` high, the prescaler sources take no samples. The subclock source (code 5) keeps filtering.
- R10: `edge_pulse` is high for one clock on each change of the filtered level that the edge mode selects. The encoding is 00 none, 01 rising, 10 falling, 11 both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| pin_async | input | 1 | Asynchronous external pin |
| sub_tick | input | 1 | Subclock sample enable, one cycle wide |
| div_stop | input | 1 | Freezes the prescaler (main divider stopped) |
| edge_sel | input | 2 | Edge mode: 00 none, 01 rise, 10 fall, 11 both |
| filt_level | output | 1 | Filtered pin level |
| edge_pulse | output | 1 | One-cycle pulse on a selected edge |

## Verification
The assertions check on every cycle that the enabled filter changes its level only on a sample strobe. They also check that prohibited codes and a frozen prescaler produce no strobe, that the unused register bits stay zero, and that every edge pulse coincides with a real change of the output. Only the bench scenarios can show the arithmetic: that each select code yields its own sample period through the latency window, that short pulses are rejected, that the history reload shortens the first decision after a write, and that each edge mode produces the expected pulse count.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
   localparam int CTRL_W     = 8;
   localparam int SEL_W      = 3;
   localparam int EN_BIT     = 7;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
   } ctrl_t;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pgf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pgf_strobe_gen.sv
module pgf_strobe_gen #(
   parameter int TAP_LO   = 6,
   parameter int NUM_TAPS = 5,
   parameter int SEL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_stop,
   input  logic             sub_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             strobe
);
   localparam int DIV_W    = TAP_LO + NUM_TAPS - 1;
   localparam int SUB_CODE = NUM_TAPS;

   if (TAP_LO < 1) begin : g_bad_tap
      $error("pgf_strobe_gen: TAP_LO must be at least 1");
   end
   if (NUM_TAPS + 1 > (1 << SEL_W)) begin : g_bad_sel
      $error("pgf_strobe_gen: select field too narrow for the taps");
   end

   logic [DIV_W-1:0]    div_q;
   logic [NUM_TAPS-1:0] tap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_q <= '0;
      else if (!div_stop) div_q <= div_q + 1'b1;
   end

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      assign tap_hit[k] = &div_q[TAP_LO+k-1:0];
   end

   always_comb begin
      strobe = 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) begin
         if (sel == SEL_W'(k)) strobe = tap_hit[k] & ~div_stop;
      end
      if (sel == SEL_W'(SUB_CODE)) strobe = sub_tick;
   end
endmodule

// File: rtl/pgf_vote.sv
module pgf_vote #(
   parameter int VOTES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic reload,
   input  logic strobe,
   input  logic d_sync,
   output logic level
);
   if (VOTES < 2) begin : g_bad_votes
      $error("pgf_vote: VOTES must be at least 2");
   end

   localparam int HIST_W = VOTES - 1;

   logic [HIST_W-1:0] hist_q;
   logic [VOTES-1:0]  window;

   assign window = {hist_q, d_sync};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         level  <= 1'b0;
      end else if (!enable) begin
         hist_q <= {HIST_W{d_sync}};
         level  <= d_sync;
      end else if (reload) begin
         hist_q <= {HIST_W{d_sync}};
      end else if (strobe) begin
         hist_q <= window[HIST_W-1:0];
         if (&window)      level <= 1'b1;
         else if (~|window) level <= 1'b0;
      end
   end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
   import pgf_pkg::*;
#(
   parameter int TAP_LO      = 6,
   parameter int NUM_TAPS    = 5,
   parameter int SYNC_STAGES = 2,
   parameter int VOTES       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              pin_async,
   input  logic              sub_tick,
   input  logic              div_stop,
   input  logic [1:0]        edge_sel,
   output logic              filt_level,
   output logic              edge_pulse
);
   ctrl_t      ctrl_q;
   logic       ctrl_en;
   logic [SEL_W-1:0] ctrl_sel;
   logic       pin_sync;
   logic       smp_strobe;
   logic       vote_level;
   logic       filt_prev;
   edge_mode_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (reg_we) ctrl_q <= '{en: reg_wdata[EN_BIT], sel: reg_wdata[SEL_W-1:0]};
   end

   assign ctrl_en   = ctrl_q.en;
   assign ctrl_sel  = ctrl_q.sel;
   assign reg_rdata = {ctrl_q.en, {(CTRL_W-SEL_W-1){1'b0}}, ctrl_q.sel};

   pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_async),
      .d_sync  (pin_sync)
   );

   pgf_strobe_gen #(.TAP_LO(TAP_LO), .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_stop (div_stop),
      .sub_tick (sub_tick),
      .sel      (ctrl_sel),
      .strobe   (smp_strobe)
   );

   pgf_vote #(.VOTES(VOTES)) u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ctrl_en),
      .reload (reg_we),
      .strobe (smp_strobe),
      .d_sync (pin_sync),
      .level  (vote_level)
   );

   assign filt_level = ctrl_en ? vote_level : pin_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_prev <= 1'b0;
      else        filt_prev <= filt_level;
   end

   assign mode = edge_mode_e'(edge_sel);

   always_comb begin
      unique case (mode)
         EDGE_RISE: edge_pulse = filt_level & ~filt_prev;
         EDGE_FALL: edge_pulse = ~filt_level & filt_prev;
         EDGE_BOTH: edge_pulse = filt_level ^ filt_prev;
         default:   edge_pulse = 1'b0;
      endcase
   end
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
   parameter int NUM_TAPS = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ctrl_en,
   input logic [2:0] ctrl_sel,
   input logic       strobe,
   input logic       level_q,
   input logic       div_stop,
   input logic       filt_level,
   input logic       edge_pulse,
   input logic [7:0] reg_rdata
);
   // R5: enabled filter level moves only on a sample strobe
   assert_level_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl_en) && !$stable(level_q)) |-> $past(strobe));

   // R2: unused register bits read zero
   assert_pad_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6:3] == 4'b0000);

   // R4: prohibited select codes never sample
   assert_no_strobe_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ctrl_sel) > NUM_TAPS) |-> !strobe);

   // R9: frozen prescaler gives no strobe on divider taps
   assert_divstop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (div_stop && int'(ctrl_sel) < NUM_TAPS) |-> !strobe);

   // R10: a pulse only accompanies a real output change
   assert_edge_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |-> (filt_level != $past(filt_level)));
endmodule

bind pin_glitch_filter pgf_checker #(.NUM_TAPS(NUM_TAPS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_en    (ctrl_en),
   .ctrl_sel   (ctrl_sel),
   .strobe     (smp_strobe),
   .level_q    (vote_level),
   .div_stop   (div_stop),
   .filt_level (filt_level),
   .edge_pulse (edge_pulse),
   .reg_rdata  (reg_rdata)
);

// File: tb/pin_glitch_filter_bench.sv
module pin_glitch_filter_bench;
   localparam int TAP_LO = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       pin_async = 1'b0;
   logic       sub_auto = 1'b0;
   logic       sub_man = 1'b0;
   logic       sub_on = 1'b0;
   logic       sub_tick;
   logic       div_stop = 1'b0;
   logic [1:0] edge_sel = 2'b11;
   logic       filt_level;
   logic       edge_pulse;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   int cyc = 0;
   int sc = 0;

   assign sub_tick = sub_auto | sub_man;

   always #2.5 clk = ~clk;

   pin_glitch_filter #(.TAP_LO(TAP_LO)) u_pin_glitch_filter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pin_async(pin_async), .sub_tick(sub_tick),
      .div_stop(div_stop), .edge_sel(edge_sel), .filt_level(filt_level),
      .edge_pulse(edge_pulse)
   );

   always @(negedge clk) begin
      if (sub_on) begin
         sc = (sc == 2) ? 0 : sc + 1;
         sub_auto = (sc == 0);
      end else begin
         sub_auto = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
         if (edge_pulse) pulses++;
      end
   endtask

   task automatic wr(input logic [7:0] v);
      reg_we = 1'b1; reg_wdata = v;
      step(1);
      reg_we = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      // R1 reset state
      chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
      chk(filt_level == 1'b0, "R1 level", filt_level, 0);
      chk(edge_pulse == 1'b0, "R1 pulse", edge_pulse, 0);
      step(2);
      rst_n = 1'b1;
      step(2);
      chk(reg_rdata == 8'h00, "R1 rdata after release", reg_rdata, 0);

      // R2 register fields
      wr(8'hFF);
      chk(reg_rdata == 8'h87, "R2 write FF", reg_rdata, 'h87);
      wr(8'h78);
      chk(reg_rdata == 8'h00, "R2 write 78", reg_rdata, 0);
      wr(8'h06);
      chk(reg_rdata == 8'h06, "R2 prohibited stored", reg_rdata, 6);
      wr(8'h00);

      // R8 pass-through
      pulses = 0; edge_sel = 2'b11;
      pin_async = 1'b1;
      step(1);
      chk(filt_level == 1'b0, "R8 one clock", filt_level, 0);
      step(1);
      chk(filt_level == 1'b1, "R8 two clocks", filt_level, 1);
      pin_async = 1'b0;
      step(3);
      chk(pulses == 2, "R8 R10 pulses", pulses, 2);

      // R3 R5 R10 sweep over codes and edge modes
      for (int c = 0; c < 5; c++) begin
         for (int es = 0; es < 4; es++) begin
            wr(8'h80 | 8'(c));
            edge_sel = 2'(es);
            for (int dir = 1; dir >= 0; dir--) begin
               int p;
               int exp_p;
               p = 1 << (TAP_LO + c);
               exp_p = dir ? es % 2 : es / 2;
               pulses = 0;
               pin_async = dir[0];
               step(2 * p + 2);
               chk(filt_level == !dir[0], $sformatf("R3 R5 early code%0d", c), filt_level, !dir[0]);
               step(p);
               chk(filt_level == dir[0], $sformatf("R3 R5 late code%0d", c), filt_level, dir[0]);
               step(2);
               chk(pulses == exp_p, $sformatf("R10 mode%0d code%0d", es, c), pulses, exp_p);
            end
         end
      end

      // R6 short pulse rejection
      edge_sel = 2'b11;
      for (int c = 0; c < 3; c++) begin
         int p;
         p = 1 << (TAP_LO + c);
         wr(8'h80 | 8'(c));
         pulses = 0;
         pin_async = 1'b1;
         step(p);
         pin_async = 1'b0;
         step(4 * p);
         chk(filt_level == 1'b0 && pulses == 0, $sformatf("R6 code%0d", c), pulses, 0);
      end

      // R4 prohibited codes hold the level
      for (int c = 6; c < 8; c++) begin
         wr(8'h80 | 8'(c));
         pin_async = 1'b1;
         step(300);
         chk(filt_level == 1'b0, $sformatf("R4 code%0d", c), filt_level, 0);
         pin_async = 1'b0;
         step(4);
      end

      // R9 frozen divider vs subclock
      wr(8'h80);
      div_stop = 1'b1;
      pin_async = 1'b1;
      step(100);
      chk(filt_level == 1'b0, "R9 divider frozen", filt_level, 0);
      pin_async = 1'b0;
      step(4);
      wr(8'h85);
      sub_on = 1'b1;
      pin_async = 1'b1;
      step(12);
      chk(filt_level == 1'b1, "R9 R3 subclock rise", filt_level, 1);
      pin_async = 1'b0;
      step(12);
      chk(filt_level == 1'b0, "R9 R3 subclock fall", filt_level, 0);
      sub_on = 1'b0;
      div_stop = 1'b0;
      step(2);

      // R7 history reload on write
      wr(8'h85);
      pin_async = 1'b1;
      step(10);
      chk(filt_level == 1'b0, "R7 no ticks", filt_level, 0);
      wr(8'h85);
      sub_man = 1'b1;
      step(1);
      sub_man = 1'b0;
      chk(filt_level == 1'b1, "R7 one sample after reload", filt_level, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule